// File: doc/BRIEF.md
# Windowed Clock Frequency Meter

This block measures how fast a test clock runs, using a reference clock whose rate in kHz is supplied as an input. The test clock is passed through a flop synchronizer into the reference domain, and its rising edges are counted over a window of a power-of-two number of reference cycles. The count is then scaled to kHz with a five-bit binary fraction. The integer part is compared with a programmable lower and upper bound, and the verdict appears as a set of status flags.

A measurement is started by a strobe that carries a nonzero source code. The meter first holds off for a programmable settle time so that an upstream clock mux can settle. It then waits for the first test-clock rising edge, which opens the window, and counts edges until the window closes. One cycle later it posts the result. The run aborts as "died" if the test clock goes quiet for too long inside the window. A strobe with a zero source code puts the meter back to idle. The bounds, settle time and window exponent sit in a small configuration register set, which a separate strobe loads.

Top module: `freq_meter`

## Requirements
- R1: After reset every status flag and the result read zero. The configuration holds lower bound 0, upper bound all ones, settle time 1 and window exponent 8.
- R2: With no test clock present, `st_waiting` rises on the (settle+1)-th clock edge after the edge that samples a nonzero start strobe, and is low before that edge.
- R3: In the waiting phase, the first detected test-clock rising edge opens a window of exactly 2^exponent reference cycles with `st_running` high. At most one of `st_waiting`, `st_running` and `st_done` is high at any time.
- R4: With E the number of test rising edges detected inside the window (the opening edge excluded), the scaled value is floor(E * ref_khz * 32 / 2^exponent). `res_khz` carries that value shifted right by 5 and `res_frac` carries its low 5 bits.
- R5: `st_done` rises one cycle after the window closes. The result and verdict flags are valid with it and hold until the next start or halt strobe. While `st_done` is low, every verdict flag is low.
- R6: `st_fast` is set when `res_khz` is above the upper bound. `st_slow` is set when `res_khz` is below the lower bound. A result equal to a bound sets neither.
- R7: When done, `st_pass` is set exactly when none of fast, slow or died is set, and `st_fail` is its complement.
- R8: If no test edge arrives for DEAD_CYC consecutive reference cycles inside the window, the run ends as done with `st_died` and `st_fail` set, `st_pass`, `st_fast` and `st_slow` clear, and a zero result.
- R9: A nonzero start strobe clears the status and result of the previous run on the next edge. A start strobe with source code 0 returns the meter to idle with all status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| test_clk | input | 1 | Clock under test, asynchronous to clk |
| ref_khz | input | 20 | Reference clock rate in kHz |
| cfg_wr | input | 1 | Loads the four configuration fields below |
| cfg_min_khz | input | 25 | Lower pass bound in kHz |
| cfg_max_khz | input | 25 | Upper pass bound in kHz |
| cfg_settle | input | 3 | Settle hold-off in cycles |
| cfg_interval | input | 4 | Window exponent |
| src_wr | input | 1 | Start strobe |
| src_sel | input | 8 | Source code; nonzero starts a run, zero halts |
| st_waiting | output | 1 | Waiting for first test edge |
| st_running | output | 1 | Window open |
| st_done | output | 1 | Measurement complete |
| st_pass | output | 1 | Result within bounds |
| st_fail | output | 1 | Run did not pass |
| st_fast | output | 1 | Result above upper bound |
| st_slow | output | 1 | Result below lower bound |
| st_died | output | 1 | Test clock stopped in window |
| res_khz | output | 25 | Integer kHz result |
| res_frac | output | 5 | Fractional kHz result in 1/32 steps |

## Verification
The assertions check the following on every cycle. The phase flags are mutually exclusive. The verdict flags stay low outside done, and pass and fail are complementary when done. A died run always fails. Halt and start strobes clear the status on the next edge. The window counter and the quiet-gap counter stay within their limits. The exact edge count, the scaled kHz and fraction values, and where fast and slow fall at the bound edges can only be shown by the bench. It sweeps the window exponent and the test period against limits set to the exact expected value and one beside it. The settle timing and the quiet-clock abort are also left to the bench's scenarios.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETTLE,
    PH_WAIT,
    PH_RUN,
    PH_CALC,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/fm_sequencer.sv
module fm_sequencer
  import fm_pkg::*;
#(
  parameter int DLY_W    = 3,
  parameter int INTV_W   = 4,
  parameter int WIN_W    = 15,
  parameter int EDGE_W   = 16,
  parameter int DEAD_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              halt,
  input  logic              tick,
  input  logic [DLY_W-1:0]  settle,
  input  logic [INTV_W-1:0] intv,
  output phase_e            phase,
  output logic [EDGE_W-1:0] edges,
  output logic              calc,
  output logic              died
);
  localparam int GAP_W = $clog2(DEAD_CYC + 1);

  logic [DLY_W-1:0] dly_cnt;
  logic [WIN_W-1:0] win_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic [WIN_W-1:0] win_mask;
  logic             win_last;
  logic             gap_out;

  assign win_mask = WIN_W'((32'd1 << intv) - 32'd1);
  assign win_last = (win_cnt == win_mask);
  assign gap_out  = !tick && (gap_cnt == GAP_W'(DEAD_CYC - 1));
  assign calc     = (phase == PH_CALC);
  assign died     = (phase == PH_RUN) && gap_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      dly_cnt <= '0;
      win_cnt <= '0;
      gap_cnt <= '0;
      edges   <= '0;
    end else if (halt) begin
      phase <= PH_IDLE;
    end else if (start) begin
      phase   <= PH_SETTLE;
      dly_cnt <= settle;
    end else begin
      case (phase)
        PH_SETTLE: begin
          if (dly_cnt == '0) phase <= PH_WAIT;
          else               dly_cnt <= dly_cnt - 1'b1;
        end
        PH_WAIT: begin
          if (tick) begin
            phase   <= PH_RUN;
            win_cnt <= '0;
            gap_cnt <= '0;
            edges   <= '0;
          end
        end
        PH_RUN: begin
          if (gap_out) begin
            phase <= PH_DONE;
          end else begin
            edges   <= edges + EDGE_W'(tick);
            gap_cnt <= tick ? '0 : gap_cnt + 1'b1;
            win_cnt <= win_cnt + 1'b1;
            if (win_last) phase <= PH_CALC;
          end
        end
        PH_CALC: phase <= PH_DONE;
        default: ;
      endcase
    end
  end

  AST_WIN_INSIDE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN) |-> (win_cnt <= win_mask)); // R3
  AST_WAIT_OPENS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT && tick && !start && !halt) |=> (phase == PH_RUN)); // R3
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN) |-> (32'(gap_cnt) < DEAD_CYC)); // R8
endmodule

// File: rtl/fm_result.sv
module fm_result #(
  parameter int REF_W  = 20,
  parameter int LIM_W  = 25,
  parameter int FRAC_W = 5,
  parameter int INTV_W = 4,
  parameter int EDGE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              calc,
  input  logic              died,
  input  logic [EDGE_W-1:0] edges,
  input  logic [REF_W-1:0]  ref_khz,
  input  logic [INTV_W-1:0] intv,
  input  logic [LIM_W-1:0]  min_khz,
  input  logic [LIM_W-1:0]  max_khz,
  output logic [LIM_W-1:0]  res_khz,
  output logic [FRAC_W-1:0] res_frac,
  output logic              fast,
  output logic              slow,
  output logic              pass,
  output logic              fail,
  output logic              died_flag
);
  localparam int PROD_W = EDGE_W + REF_W + FRAC_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;
  logic [LIM_W-1:0]  khz_n;
  logic              fast_n;
  logic              slow_n;

  assign prod   = (PROD_W'(edges) * PROD_W'(ref_khz)) << FRAC_W;
  assign scaled = prod >> intv;
  assign khz_n  = scaled[FRAC_W +: LIM_W];
  assign fast_n = (khz_n > max_khz);
  assign slow_n = (khz_n < min_khz);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      res_khz   <= '0;
      res_frac  <= '0;
      fast      <= 1'b0;
      slow      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      died_flag <= 1'b0;
    end else if (died) begin
      died_flag <= 1'b1;
      fail      <= 1'b1;
    end else if (calc) begin
      res_khz  <= khz_n;
      res_frac <= scaled[FRAC_W-1:0];
      fast     <= fast_n;
      slow     <= slow_n;
      pass     <= !fast_n && !slow_n;
      fail     <= fast_n || slow_n;
    end
  end

  AST_NOT_BOTH_WAYS: assert property (@(posedge clk) disable iff (rst)
    (calc && !clear && !died && min_khz <= max_khz) |=> !(fast && slow)); // R6
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int REF_W       = 20,
  parameter int LIM_W       = 25,
  parameter int FRAC_W      = 5,
  parameter int DLY_W       = 3,
  parameter int INTV_W      = 4,
  parameter int SRC_W       = 8,
  parameter int DEAD_CYC    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_clk,
  input  logic [REF_W-1:0]  ref_khz,
  input  logic              cfg_wr,
  input  logic [LIM_W-1:0]  cfg_min_khz,
  input  logic [LIM_W-1:0]  cfg_max_khz,
  input  logic [DLY_W-1:0]  cfg_settle,
  input  logic [INTV_W-1:0] cfg_interval,
  input  logic              src_wr,
  input  logic [SRC_W-1:0]  src_sel,
  output logic              st_waiting,
  output logic              st_running,
  output logic              st_done,
  output logic              st_pass,
  output logic              st_fail,
  output logic              st_fast,
  output logic              st_slow,
  output logic              st_died,
  output logic [LIM_W-1:0]  res_khz,
  output logic [FRAC_W-1:0] res_frac
);
  localparam int WIN_W  = (1 << INTV_W) - 1;
  localparam int EDGE_W = WIN_W + 1;

  logic [LIM_W-1:0]  min_q;
  logic [LIM_W-1:0]  max_q;
  logic [DLY_W-1:0]  settle_q;
  logic [INTV_W-1:0] intv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      min_q    <= '0;
      max_q    <= '1;
      settle_q <= DLY_W'(1);
      intv_q   <= INTV_W'(8);
    end else if (cfg_wr) begin
      min_q    <= cfg_min_khz;
      max_q    <= cfg_max_khz;
      settle_q <= cfg_settle;
      intv_q   <= cfg_interval;
    end
  end

  logic              start;
  logic              halt;
  logic              tick;
  logic              calc;
  logic              died;
  phase_e            phase;
  logic [EDGE_W-1:0] edges;

  assign start = src_wr && (src_sel != '0);
  assign halt  = src_wr && (src_sel == '0);

  fm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(test_clk), .rise(tick)
  );

  fm_sequencer #(
    .DLY_W(DLY_W), .INTV_W(INTV_W), .WIN_W(WIN_W),
    .EDGE_W(EDGE_W), .DEAD_CYC(DEAD_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .halt(halt), .tick(tick),
    .settle(settle_q), .intv(intv_q), .phase(phase), .edges(edges),
    .calc(calc), .died(died)
  );

  fm_result #(
    .REF_W(REF_W), .LIM_W(LIM_W), .FRAC_W(FRAC_W),
    .INTV_W(INTV_W), .EDGE_W(EDGE_W)
  ) u_res (
    .clk(clk), .rst(rst), .clear(start || halt), .calc(calc), .died(died),
    .edges(edges), .ref_khz(ref_khz), .intv(intv_q),
    .min_khz(min_q), .max_khz(max_q),
    .res_khz(res_khz), .res_frac(res_frac), .fast(st_fast), .slow(st_slow),
    .pass(st_pass), .fail(st_fail), .died_flag(st_died)
  );

  assign st_waiting = (phase == PH_WAIT);
  assign st_running = (phase == PH_RUN);
  assign st_done    = (phase == PH_DONE);

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_waiting, st_running, st_done})); // R3
  AST_FLAGS_NEED_DONE: assert property (@(posedge clk) disable iff (rst)
    !st_done |-> !(st_pass || st_fail || st_fast || st_slow || st_died)); // R5
  AST_VERDICT: assert property (@(posedge clk) disable iff (rst)
    st_done |-> (st_pass != st_fail)); // R7
  AST_DIED_FAILS: assert property (@(posedge clk) disable iff (rst)
    st_died |-> (st_fail && !st_pass && !st_fast && !st_slow)); // R8
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (rst)
    halt |=> !(st_waiting || st_running || st_done || st_fail)); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> !(st_done || st_pass || st_fail || st_died)); // R9
endmodule

// File: tb/freq_meter_tb.sv
module freq_meter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        test_clk = 1'b0;
  logic [19:0] ref_khz = '0;
  logic        cfg_wr = 1'b0;
  logic [24:0] cfg_min_khz = '0;
  logic [24:0] cfg_max_khz = '0;
  logic [2:0]  cfg_settle = '0;
  logic [3:0]  cfg_interval = '0;
  logic        src_wr = 1'b0;
  logic [7:0]  src_sel = '0;
  logic st_waiting, st_running, st_done, st_pass, st_fail;
  logic st_fast, st_slow, st_died;
  logic [24:0] res_khz;
  logic [4:0]  res_frac;

  int vecs = 0;
  int errs = 0;
  bit tc_en = 1'b0;
  int tc_per = 4;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_meter #(.DEAD_CYC(DEAD)) u_dut (
    .clk(clk), .rst(rst), .test_clk(test_clk), .ref_khz(ref_khz),
    .cfg_wr(cfg_wr), .cfg_min_khz(cfg_min_khz), .cfg_max_khz(cfg_max_khz),
    .cfg_settle(cfg_settle), .cfg_interval(cfg_interval),
    .src_wr(src_wr), .src_sel(src_sel),
    .st_waiting(st_waiting), .st_running(st_running), .st_done(st_done),
    .st_pass(st_pass), .st_fail(st_fail), .st_fast(st_fast),
    .st_slow(st_slow), .st_died(st_died), .res_khz(res_khz), .res_frac(res_frac)
  );

  // test clock: rising edge every tc_per reference cycles, changed at negedge
  initial begin
    int tcnt;
    tcnt = 0;
    forever begin
      @(negedge clk);
      if (!tc_en) begin
        tcnt = 0;
        test_clk = 1'b0;
      end else begin
        test_clk = (tcnt < tc_per / 2);
        tcnt = (tcnt == tc_per - 1) ? 0 : tcnt + 1;
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic configure(input int mn, input int mx, input int dly, input int iv);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_min_khz = 25'(mn);
    cfg_max_khz = 25'(mx);
    cfg_settle = 3'(dly);
    cfg_interval = 4'(iv);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic strobe(input int code);
    @(negedge clk);
    src_wr = 1'b1;
    src_sel = 8'(code);
    @(negedge clk);
    src_wr = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (!st_done && n < 40000) begin
      @(negedge clk);
      n++;
    end
    check({tag, " done reached"}, st_done, 1);
  endtask

  function automatic longint scaled(input int e, input int rk, input int iv);
    return (longint'(e) * rk * 32) >> iv;
  endfunction

  task automatic settle_probe(input int dly);
    tc_en = 1'b0;
    strobe(1);
    repeat (dly) @(negedge clk);
    check("R2 waiting low before settle end", st_waiting, 0);
    @(negedge clk);
    check("R2 waiting high after settle", st_waiting, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 waiting", st_waiting, 0);
    check("R1 running", st_running, 0);
    check("R1 done", st_done, 0);
    check("R1 pass", st_pass, 0);
    check("R1 fail", st_fail, 0);
    check("R1 khz", res_khz, 0);

    // R1 default config: settle 1, window 2^8, bounds 0..all-ones
    ref_khz = 20'd12800;
    settle_probe(1);
    tc_per = 4;
    tc_en = 1'b1;
    wait_done("R1 default");
    check("R1 default khz", res_khz, scaled(256 / 4, 12800, 8) >> 5);
    check("R1 default frac", res_frac, 0);
    check("R1 default pass", st_pass, 1);

    // R9 restart clears
    tc_en = 1'b0;
    strobe(3);
    check("R9 restart done", st_done, 0);
    check("R9 restart pass", st_pass, 0);
    check("R9 restart khz", res_khz, 0);

    // R2 longer settle
    configure(0, 32'h1ffffff, 5, 3);
    settle_probe(5);
    configure(0, 32'h1ffffff, 0, 3);
    settle_probe(0);

    // R4 R5 R6 R7 sweep
    ref_khz = 20'd10001;
    for (int iv = 3; iv <= 7; iv++) begin
      for (int pi = 0; pi < 4; pi++) begin
        for (int mode = 0; mode < 3; mode++) begin
          int per, w, e, ek, mn, mx;
          longint fx;
          per = (pi == 0) ? 2 : (pi == 1) ? 3 : (pi == 2) ? 5 : 8;
          w = 1 << iv;
          e = w / per;
          fx = scaled(e, 10001, iv);
          ek = int'(fx >> 5);
          mn = (mode == 2) ? ek + 1 : (mode == 0) ? ek : 0;
          mx = (mode == 1) ? ek - 1 : (mode == 0) ? ek : 32'h1ffffff;
          tc_en = 1'b0;
          configure(mn, mx, 1, iv);
          tc_per = per;
          strobe(5);
          tc_en = 1'b1;
          wait_done("R5 sweep");
          check("R4 khz", res_khz, ek);
          check("R4 frac", res_frac, fx & 31);
          check("R6 fast", st_fast, (mode == 1) ? 1 : 0);
          check("R6 slow", st_slow, (mode == 2) ? 1 : 0);
          check("R7 pass", st_pass, (mode == 0) ? 1 : 0);
          check("R7 fail", st_fail, (mode == 0) ? 0 : 1);
          repeat (3) @(negedge clk);
          check("R5 result held", res_khz, ek);
        end
      end
    end

    // R8 test clock dies mid-window
    tc_en = 1'b0;
    configure(0, 32'h1ffffff, 1, 7);
    tc_per = 4;
    strobe(2);
    tc_en = 1'b1;
    while (!st_running) @(negedge clk);
    repeat (10) @(negedge clk);
    tc_en = 1'b0;
    wait_done("R8 died");
    check("R8 died", st_died, 1);
    check("R8 fail", st_fail, 1);
    check("R8 pass", st_pass, 0);
    check("R8 fast", st_fast, 0);
    check("R8 khz", res_khz, 0);

    // R9 halt mid-run
    strobe(2);
    tc_en = 1'b1;
    while (!st_running) @(negedge clk);
    strobe(0);
    check("R9 halt running", st_running, 0);
    check("R9 halt waiting", st_waiting, 0);
    repeat (300) @(negedge clk);
    check("R9 halt stays idle", st_done, 0);
    tc_en = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule